// File: doc/BRIEF.md
# Phase-Frequency Detector with Pump Control

This block compares two single-cycle pulse streams and turns the phase and frequency error between them into pump requests. One stream comes from the reference divider and the other from the feedback divider of a synthesis loop. Two pump request pairs are produced. The second pair always follows the detector. The first pair is gated by a two-bit mode field and, in some modes, by an external lock indication. A gain code is translated into a pump-1 current value and a pump-2 multiplier value for the analog side.

The detector is built from two set flops. The first input pulse to arrive sets one flop, and the later pulse sets the other. When both flops are set, they stay set together for a programmable number of clock cycles (`MIN_OVERLAP`) and then clear together. Because of this forced overlap, a phase error of zero still produces a short pulse of equal width on both outputs. The response therefore has no dead zone around zero error.

A sense bit exchanges the two detector inputs, so the loop's correction direction can be flipped. It also exchanges which divider pulse appears on each of the two registered monitor outputs. The mode field decides whether those monitor outputs are driven at all. All pump, monitor and gain pins are plain control signals. The block has no streaming data path and therefore no valid/ready handshake.

Top module: `pfd_pump_ctrl`

## Requirements
- R1: While `rst_n` is low, every pump request and monitor output is 0, and pulses seen during reset leave no request pending afterwards.
- R2: With `sense`=0, a `ref_pulse` sampled at a rising edge raises `pump2_up` after that edge. A `fb_pulse` sampled at a rising edge raises `pump2_dn` after that edge.
- R3: Once both requests are high, both stay high for exactly `MIN_OVERLAP` cycles and then fall together. If one input leads the other by d cycles, the leading request is high for d+`MIN_OVERLAP` cycles and the lagging request for `MIN_OVERLAP` cycles. If d=0, both are high for `MIN_OVERLAP` cycles.
- R4: Extra pulses on the leading input while its request is already high add nothing. The request stays high until the other input arrives, so a frequency error gives a single long pulse.
- R5: With `sense`=1, `fb_pulse` drives the up requests and `ref_pulse` drives the down requests.
- R6: `pump1_ua` gives the pump-1 current in microamps, and `pump2_mult2` gives twice the pump-2 multiplier. For `gain` = 0, 1, 2, 3 these are 50, 75, 125, 200 and 2, 3, 5, 8 respectively.
- R7: The monitor outputs are driven only when `mode[1]`=1; when `mode[1]`=0 both are 0. When driven, `mon_a` is a one-cycle copy of `ref_pulse` (sense 0) or `fb_pulse` (sense 1), registered one cycle after the input edge. `mon_b` carries the other pulse with the same timing.
- R8: Pump 1 follows the detector in mode 00. It is held off in mode 10. In modes 01 and 11 it is held off whenever `lock_in`=1 and follows the detector when `lock_in`=0. The gating by `lock_in` takes effect in the same cycle.
- R9: `pump2_up`/`pump2_dn` follow the detector in every mode and for every `lock_in` value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_pulse | input | 1 | Reference divider pulse, one cycle wide |
| fb_pulse | input | 1 | Feedback divider pulse, one cycle wide |
| sense | input | 1 | 1 swaps the detector inputs and the monitor outputs |
| gain | input | 2 | Gain code |
| mode | input | 2 | Mode field; bit 1 enables the monitors, bit 0 selects lock gating |
| lock_in | input | 1 | External lock indication |
| pump1_up | output | 1 | Pump-1 up request |
| pump1_dn | output | 1 | Pump-1 down request |
| pump2_up | output | 1 | Pump-2 up request |
| pump2_dn | output | 1 | Pump-2 down request |
| pump1_ua | output | UA_W | Pump-1 current in microamps |
| pump2_mult2 | output | MULT_W | Pump-2 multiplier times two |
| mon_a | output | 1 | Monitor output A |
| mon_b | output | 1 | Monitor output B |

## Verification
The bench builds the block with `MIN_OVERLAP`=2 and keeps the default code widths. With an overlap of two cycles, the forced overlap can be told apart from the one-cycle input pulses. This exposes an off-by-one in the release counter, which the default of 1 would hide, and the counter-based generate branch is the one exercised. The measured pulse widths are checked for a reference lead, a feedback lead, equal phase, a frequency error and the swapped sense. All eight combinations of mode and lock level are walked with a fixed lead.

// File: rtl/pfd_pkg.sv
`timescale 1ns/1ps
package pfd_pkg;
  typedef enum logic [1:0] {
    MODE_BOTH_ON      = 2'b00,
    MODE_LOCK_GATE    = 2'b01,
    MODE_MON_P1_OFF   = 2'b10,
    MODE_MON_LOCKGATE = 2'b11
  } pump_mode_e;

  // Pump-1 current per gain code, microamps
  localparam int unsigned GAIN_UA    [4] = '{50, 75, 125, 200};
  // Pump-2 multiplier per gain code, in half steps
  localparam int unsigned GAIN_MULT2 [4] = '{2, 3, 5, 8};
endpackage

// File: rtl/pfd_core.sv
`timescale 1ns/1ps
module pfd_core #(
  parameter int unsigned MIN_OVERLAP = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a_pulse,
  input  logic b_pulse,
  output logic up_o,
  output logic dn_o
);
  logic up_q, dn_q, both, release_now;

  assign both = up_q & dn_q;

  generate
    if (MIN_OVERLAP <= 1) begin : g_single
      assign release_now = both;
    end else begin : g_count
      localparam int unsigned CW = $clog2(MIN_OVERLAP);
      localparam logic [CW-1:0] LAST = CW'(MIN_OVERLAP - 1);
      logic [CW-1:0] ov_cnt;

      always_ff @(posedge clk) begin
        if (!rst_n)                   ov_cnt <= '0;
        else if (both && !release_now) ov_cnt <= ov_cnt + 1'b1;
        else                          ov_cnt <= '0;
      end

      assign release_now = both && (ov_cnt == LAST);

      // R3: the overlap counter never passes its limit
      a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        both |-> ov_cnt <= LAST);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (release_now) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_q | a_pulse;
      dn_q <= dn_q | b_pulse;
    end
  end

  assign up_o = up_q;
  assign dn_o = dn_q;

  a_r2_up_set: assert property (@(posedge clk) disable iff (!rst_n)
    a_pulse && !both |=> up_q);
  a_r2_dn_set: assert property (@(posedge clk) disable iff (!rst_n)
    b_pulse && !both |=> dn_q);
  a_r3_fall_together: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(up_q) |-> $fell(dn_q));
  a_r3_fall_together_dn: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dn_q) |-> $fell(up_q));
  a_r4_up_held: assert property (@(posedge clk) disable iff (!rst_n)
    up_q && !dn_q |=> up_q);
endmodule

// File: rtl/pfd_gain_map.sv
`timescale 1ns/1ps
module pfd_gain_map #(
  parameter int unsigned UA_W   = 8,
  parameter int unsigned MULT_W = 4
) (
  input  logic [1:0]        gain,
  output logic [UA_W-1:0]   ua,
  output logic [MULT_W-1:0] mult2
);
  import pfd_pkg::*;

  assign ua    = UA_W'(GAIN_UA[gain]);
  assign mult2 = MULT_W'(GAIN_MULT2[gain]);
endmodule

// File: rtl/pfd_mode_ctrl.sv
`timescale 1ns/1ps
module pfd_mode_ctrl (
  input  logic [1:0] mode,
  input  logic       lock_in,
  output logic       mon_en,
  output logic       p1_en
);
  import pfd_pkg::*;
  pump_mode_e m;

  assign m = pump_mode_e'(mode);

  always_comb begin
    mon_en = 1'b0;
    p1_en  = 1'b1;
    case (m)
      MODE_BOTH_ON:      begin mon_en = 1'b0; p1_en = 1'b1;     end
      MODE_LOCK_GATE:    begin mon_en = 1'b0; p1_en = !lock_in; end
      MODE_MON_P1_OFF:   begin mon_en = 1'b1; p1_en = 1'b0;     end
      MODE_MON_LOCKGATE: begin mon_en = 1'b1; p1_en = !lock_in; end
      default:           begin mon_en = 1'b0; p1_en = 1'b1;     end
    endcase
  end
endmodule

// File: rtl/pfd_pump_ctrl.sv
`timescale 1ns/1ps
module pfd_pump_ctrl #(
  parameter int unsigned MIN_OVERLAP = 1,
  parameter int unsigned UA_W        = 8,
  parameter int unsigned MULT_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_pulse,
  input  logic              fb_pulse,
  input  logic              sense,
  input  logic [1:0]        gain,
  input  logic [1:0]        mode,
  input  logic              lock_in,
  output logic              pump1_up,
  output logic              pump1_dn,
  output logic              pump2_up,
  output logic              pump2_dn,
  output logic [UA_W-1:0]   pump1_ua,
  output logic [MULT_W-1:0] pump2_mult2,
  output logic              mon_a,
  output logic              mon_b
);
  logic a_in, b_in, det_up, det_dn, mon_en, p1_en;
  logic mon_a_q, mon_b_q;

  // Sense bit exchanges the detector inputs and the monitor routing
  assign a_in = sense ? fb_pulse  : ref_pulse;
  assign b_in = sense ? ref_pulse : fb_pulse;

  pfd_core #(.MIN_OVERLAP(MIN_OVERLAP)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_pulse (a_in),
    .b_pulse (b_in),
    .up_o    (det_up),
    .dn_o    (det_dn)
  );

  pfd_gain_map #(.UA_W(UA_W), .MULT_W(MULT_W)) u_gain (
    .gain  (gain),
    .ua    (pump1_ua),
    .mult2 (pump2_mult2)
  );

  pfd_mode_ctrl u_mode (
    .mode    (mode),
    .lock_in (lock_in),
    .mon_en  (mon_en),
    .p1_en   (p1_en)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mon_a_q <= 1'b0;
      mon_b_q <= 1'b0;
    end else begin
      mon_a_q <= mon_en & a_in;
      mon_b_q <= mon_en & b_in;
    end
  end

  assign mon_a    = mon_a_q;
  assign mon_b    = mon_b_q;
  assign pump1_up = det_up & p1_en;
  assign pump1_dn = det_dn & p1_en;
  assign pump2_up = det_up;
  assign pump2_dn = det_dn;

  a_r5_swap_fb_up: assert property (@(posedge clk) disable iff (!rst_n)
    sense && fb_pulse && !(pump2_up && pump2_dn) |=> pump2_up);
  a_r6_gain_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (pump1_ua == UA_W'(50)) || (pump1_ua == UA_W'(75)) ||
    (pump1_ua == UA_W'(125)) || (pump1_ua == UA_W'(200)));
  a_r7_mon_off: assert property (@(posedge clk) disable iff (!rst_n)
    !mode[1] |=> !mon_a && !mon_b);
  a_r8_p1_off: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b10 |-> !pump1_up && !pump1_dn);
  a_r8_lock_gate: assert property (@(posedge clk) disable iff (!rst_n)
    mode[0] && lock_in |-> !pump1_up && !pump1_dn);
  a_r8_both_on: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b00 |-> pump1_up == pump2_up && pump1_dn == pump2_dn);
endmodule

// File: tb/tb_pfd_pump_ctrl.sv
`timescale 1ns/1ps
module tb_pfd_pump_ctrl;
  localparam int unsigned OVL = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_pulse = 1'b0, fb_pulse = 1'b0, sense = 1'b0, lock_in = 1'b0;
  logic [1:0] gain = 2'b00, mode = 2'b00;
  logic pump1_up, pump1_dn, pump2_up, pump2_dn, mon_a, mon_b;
  logic [7:0] pump1_ua;
  logic [3:0] pump2_mult2;

  int checks = 0;
  int fails  = 0;
  int w_up2, w_dn2, w_up1, w_dn1, n_mona, n_monb, first_mona, first_monb;

  // {mode[1:0], lock, pump1 expected active, monitors expected driven}
  localparam logic [4:0] MODE_VEC [8] = '{
    5'b00_0_1_0, 5'b00_1_1_0, 5'b01_0_1_0, 5'b01_1_0_0,
    5'b10_0_0_1, 5'b10_1_0_1, 5'b11_0_1_1, 5'b11_1_0_1
  };
  localparam int unsigned EXP_UA [4]    = '{50, 75, 125, 200};
  localparam int unsigned EXP_MULT2 [4] = '{2, 3, 5, 8};

  always #5 clk = ~clk;

  pfd_pump_ctrl #(.MIN_OVERLAP(OVL), .UA_W(8), .MULT_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
    .sense(sense), .gain(gain), .mode(mode), .lock_in(lock_in),
    .pump1_up(pump1_up), .pump1_dn(pump1_dn), .pump2_up(pump2_up),
    .pump2_dn(pump2_dn), .pump1_ua(pump1_ua), .pump2_mult2(pump2_mult2),
    .mon_a(mon_a), .mon_b(mon_b)
  );

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // Drive ref at cycles r0/r1 and fb at f0 (-1 = none); measure widths.
  task automatic run_sched(input int r0, input int r1, input int f0);
    w_up2 = 0; w_dn2 = 0; w_up1 = 0; w_dn1 = 0;
    n_mona = 0; n_monb = 0; first_mona = -1; first_monb = -1;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (pump2_up) w_up2++;
      if (pump2_dn) w_dn2++;
      if (pump1_up) w_up1++;
      if (pump1_dn) w_dn1++;
      if (mon_a) begin n_mona++; if (first_mona < 0) first_mona = i; end
      if (mon_b) begin n_monb++; if (first_monb < 0) first_monb = i; end
      ref_pulse = (i == r0) || (i == r1);
      fb_pulse  = (i == f0);
    end
    ref_pulse = 1'b0;
    fb_pulse  = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state, pulses during reset ignored
    ref_pulse = 1'b1;
    mode = 2'b11;
    repeat (3) @(negedge clk);
    chk("R1 pump2_up in reset", int'(pump2_up), 0);
    chk("R1 pump1_up in reset", int'(pump1_up), 0);
    chk("R1 mon_a in reset", int'(mon_a), 0);
    ref_pulse = 1'b0;
    mode = 2'b00;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 no pending up after reset", int'(pump2_up), 0);
    chk("R1 no pending dn after reset", int'(pump2_dn), 0);

    // R6: gain mapping
    for (int g = 0; g < 4; g++) begin
      gain = 2'(g);
      #1;
      chk($sformatf("R6 pump1_ua gain %0d", g), int'(pump1_ua), int'(EXP_UA[g]));
      chk($sformatf("R6 pump2_mult2 gain %0d", g), int'(pump2_mult2), int'(EXP_MULT2[g]));
    end

    // R7 R8 R9: walk every mode and lock level with ref leading by 3
    for (int k = 0; k < 8; k++) begin
      mode    = MODE_VEC[k][4:3];
      lock_in = MODE_VEC[k][2];
      run_sched(0, -1, 3);
      chk($sformatf("R9 pump2_up row %0d", k), w_up2, 3 + OVL);
      chk($sformatf("R9 pump2_dn row %0d", k), w_dn2, OVL);
      chk($sformatf("R8 pump1_up row %0d", k), w_up1, MODE_VEC[k][1] ? 3 + OVL : 0);
      chk($sformatf("R8 pump1_dn row %0d", k), w_dn1, MODE_VEC[k][1] ? OVL : 0);
      chk($sformatf("R7 mon_a count row %0d", k), n_mona, MODE_VEC[k][0] ? 1 : 0);
      chk($sformatf("R7 mon_b count row %0d", k), n_monb, MODE_VEC[k][0] ? 1 : 0);
    end
    mode = 2'b00;
    lock_in = 1'b0;

    // R2 R3: feedback leads by 4
    run_sched(4, -1, 0);
    chk("R3 fb lead dn width", w_dn2, 4 + OVL);
    chk("R3 fb lead up width", w_up2, OVL);

    // R3: equal phase gives the minimum overlap on both
    run_sched(0, -1, 0);
    chk("R3 equal up width", w_up2, OVL);
    chk("R3 equal dn width", w_dn2, OVL);

    // R4: extra reference pulse while up is already high
    run_sched(0, 2, 6);
    chk("R4 freq up width", w_up2, 6 + OVL);
    chk("R4 freq dn width", w_dn2, OVL);

    // R7: monitor timing, sense 0
    mode = 2'b11;
    run_sched(0, -1, 3);
    chk("R7 mon_a first cycle sense0", first_mona, 1);
    chk("R7 mon_b first cycle sense0", first_monb, 4);

    // R5: sense swaps detector and monitors
    sense = 1'b1;
    run_sched(0, -1, 3);
    chk("R5 swapped dn width", w_dn2, 3 + OVL);
    chk("R5 swapped up width", w_up2, OVL);
    chk("R5 mon_a carries fb", first_mona, 4);
    chk("R5 mon_b carries ref", first_monb, 1);

    // R8: lock gating takes effect in the same cycle
    sense = 1'b0;
    mode = 2'b01;
    @(negedge clk); ref_pulse = 1'b1;
    @(negedge clk); ref_pulse = 1'b0;
    chk("R8 pump1_up before lock", int'(pump1_up), 1);
    lock_in = 1'b1;
    #1;
    chk("R8 pump1_up gated by lock", int'(pump1_up), 0);
    chk("R9 pump2_up with lock", int'(pump2_up), 1);
    lock_in = 1'b0;
    #1;
    chk("R8 pump1_up lock released", int'(pump1_up), 1);
    @(negedge clk); fb_pulse = 1'b1;
    @(negedge clk); fb_pulse = 1'b0;
    repeat (OVL + 1) @(negedge clk);
    chk("R3 idle after close up", int'(pump2_up), 0);
    chk("R3 idle after close dn", int'(pump2_dn), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule